// File: doc/BRIEF.md
# Four-Channel PWM Controller with Shared Period Generators

This block drives four pulse-width-modulated outputs from a shared pool of four period generators. Each generator divides the input clock by a programmable 16-bit divisor to make a tick. A fixed number of ticks (2^DUTY_W, which is 256 by default) makes one period. Each channel holds a duty value and a two-bit field that names the generator it follows. The channel output is high while the selected generator's tick count is below the channel's duty value.

Software sets up the block through a small single-cycle register bus. Each channel has three controls: an output-enable bit, a clock-source-enable bit and a bypass bit that holds the output high for full duty. New divisor, duty and generator-select values take effect only at the next period boundary, so a running period always completes. A disabled channel drives low. A generator that no enabled channel uses is held in reset. A channel that is enabled again therefore starts a fresh period.

Top module: `pwm_multi`

## Requirements
- R1: After reset every register reads zero and every output is low.
- R2: The register map uses byte offsets. Offset 0x000 holds output enables in bits [3:0] and bypass bits in [11:8]. Offset 0x004 holds clock-source enables in bits [3:0]. Offset 0x008+4·n holds the divisor of generator n in bits [15:0]. Offset 0x018+4·n holds channel n's duty in bits [DUTY_W-1:0] and its generator select in bits [9:8]. Every other bit reads zero.
- R3: A channel running from generator g, with divisor F>0 and duty D, repeats a period of F·2^DUTY_W clock cycles. In each period the output is high for the first D·F cycles and low for the rest.
- R4: The select field of channel n picks which of the four generators (0 to 3) times that channel. Several channels may share one generator.
- R5: A channel's output toggles only while both its output-enable bit and its clock-enable bit are set. Otherwise the output is low from the second clock edge after the change.
- R6: While a channel is enabled and its bypass bit is set, the output is high from the second clock edge after the write, whatever its duty value.
- R7: A divisor of 0 holds its generator stopped. A channel on a stopped generator is low unless bypass is set. The first period starts one cycle after a nonzero divisor is written.
- R8: Writes to duty, select or divisor during a period do not change that period. The new values apply from the next period boundary of the generator the channel is following.
- R9: Clearing a channel's enable resets the counters of any generator that no enabled channel uses. The channel restarts at the start of a period, and its output goes high at the second edge after the enable write.
- R10: Writes to unmapped or unaligned addresses change no register, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic and the count base of the generators |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr, valid in the same cycle |
| pwm_o | output | NUM_CH | Registered PWM outputs, one per channel |

## Verification
The bench builds the block with DUTY_W = 4, so a period is 16 ticks. It keeps the full 16-bit divisor and all four channels. Short periods let the bench compare every duty value against small divisors cycle by cycle, over two full periods, against an arithmetic waveform. They also make the period-boundary hand-over of duty, divisor and generator select visible within a few dozen cycles. The four-channel runs give each channel its own generator and divisor, in two different select mappings.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // bus data width
    localparam int BUS_W = 32;

    // fixed byte offsets of the two control words
    localparam int OFS_OUT_CTRL = 'h000;
    localparam int OFS_CLK_CTRL = 'h004;
    // first divisor word; duty words follow the divisor block
    localparam int OFS_DIV_BASE = 'h008;

    // field positions that software decodes
    localparam int BYP_LSB = 8;
    localparam int SEL_LSB = 8;

    function automatic int div_ofs(input int idx);
        return OFS_DIV_BASE + 4 * idx;
    endfunction

    function automatic int duty_ofs(input int nch, input int idx);
        return OFS_DIV_BASE + 4 * nch + 4 * idx;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 16,
    parameter int DUTY_W = 8,
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic                                bus_we,
    input  logic [pwm_pkg::BUS_W-1:0]           bus_wdata,
    output logic [pwm_pkg::BUS_W-1:0]           bus_rdata,
    output logic [NUM_CH-1:0]                   out_en,
    output logic [NUM_CH-1:0]                   clk_en,
    output logic [NUM_CH-1:0]                   byp,
    output logic [NUM_CH-1:0][DIV_W-1:0]        div,
    output logic [NUM_CH-1:0][DUTY_W-1:0]       duty,
    output logic [NUM_CH-1:0][SEL_W-1:0]        sel
);
    import pwm_pkg::*;

    typedef struct packed {
        logic [NUM_CH-1:0]              out_en;
        logic [NUM_CH-1:0]              clk_en;
        logic [NUM_CH-1:0]              byp;
        logic [NUM_CH-1:0][DIV_W-1:0]   div;
        logic [NUM_CH-1:0][DUTY_W-1:0]  duty;
        logic [NUM_CH-1:0][SEL_W-1:0]   sel;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [BUS_W-1:0] rdata_d;

    always_comb begin
        regs_d  = regs_q;
        rdata_d = '0;

        if (bus_addr == ADDR_W'(OFS_OUT_CTRL)) begin
            rdata_d[NUM_CH-1:0]        = regs_q.out_en;
            rdata_d[BYP_LSB +: NUM_CH] = regs_q.byp;
            if (bus_we) begin
                regs_d.out_en = bus_wdata[NUM_CH-1:0];
                regs_d.byp    = bus_wdata[BYP_LSB +: NUM_CH];
            end
        end

        if (bus_addr == ADDR_W'(OFS_CLK_CTRL)) begin
            rdata_d[NUM_CH-1:0] = regs_q.clk_en;
            if (bus_we) begin
                regs_d.clk_en = bus_wdata[NUM_CH-1:0];
            end
        end

        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(div_ofs(c))) begin
                rdata_d[DIV_W-1:0] = regs_q.div[c];
                if (bus_we) begin
                    regs_d.div[c] = bus_wdata[DIV_W-1:0];
                end
            end
            if (bus_addr == ADDR_W'(duty_ofs(NUM_CH, c))) begin
                rdata_d[DUTY_W-1:0]        = regs_q.duty[c];
                rdata_d[SEL_LSB +: SEL_W]  = regs_q.sel[c];
                if (bus_we) begin
                    regs_d.duty[c] = bus_wdata[DUTY_W-1:0];
                    regs_d.sel[c]  = bus_wdata[SEL_LSB +: SEL_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata = rdata_d;
    assign out_en    = regs_q.out_en;
    assign clk_en    = regs_q.clk_en;
    assign byp       = regs_q.byp;
    assign div       = regs_q.div;
    assign duty      = regs_q.duty;
    assign sel       = regs_q.sel;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int DIV_W  = 16,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic [DUTY_W-1:0] tick_o,
    output logic              stop_o,
    output logic              wrap_o
);
    typedef struct packed {
        logic [DIV_W-1:0]  pre;
        logic [DUTY_W-1:0] tick;
        logic [DIV_W-1:0]  div;
    } tb_t;

    tb_t tb_d, tb_q;
    logic stopped;
    logic pre_last;
    logic at_wrap;

    always_comb begin
        stopped  = (tb_q.div == '0);
        pre_last = (tb_q.pre == DIV_W'(tb_q.div - DIV_W'(1)));
        at_wrap  = stopped || (pre_last && (tb_q.tick == '1));
        tb_d     = tb_q;

        if (!run_i) begin
            // idle: hold at the start of a period, keep the divisor fresh
            tb_d.pre  = '0;
            tb_d.tick = '0;
            tb_d.div  = div_i;
        end else if (stopped) begin
            tb_d.pre  = '0;
            tb_d.tick = '0;
            tb_d.div  = div_i;
        end else begin
            if (pre_last) begin
                tb_d.pre  = '0;
                tb_d.tick = DUTY_W'(tb_q.tick + DUTY_W'(1));
            end else begin
                tb_d.pre  = DIV_W'(tb_q.pre + DIV_W'(1));
            end
            if (at_wrap) begin
                tb_d.div = div_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    assign tick_o = tb_q.tick;
    assign stop_o = stopped;
    assign wrap_o = at_wrap;

endmodule

// File: rtl/pwm_lane.sv
module pwm_lane #(
    parameter int NUM_GEN = 4,
    parameter int DUTY_W  = 8,
    parameter int SEL_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              act_i,
    input  logic                              byp_i,
    input  logic [DUTY_W-1:0]                 duty_i,
    input  logic [SEL_W-1:0]                  sel_i,
    input  logic [NUM_GEN-1:0][DUTY_W-1:0]    gen_tick_i,
    input  logic [NUM_GEN-1:0]                gen_stop_i,
    input  logic [NUM_GEN-1:0]                gen_wrap_i,
    output logic [SEL_W-1:0]                  sel_o,
    output logic                              pwm_o
);
    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic [SEL_W-1:0]  sel;
        logic              out;
    } lane_t;

    lane_t lane_d, lane_q;
    logic  my_wrap;
    logic  my_stop;
    logic [DUTY_W-1:0] my_tick;

    always_comb begin
        my_wrap = gen_wrap_i[lane_q.sel];
        my_stop = gen_stop_i[lane_q.sel];
        my_tick = gen_tick_i[lane_q.sel];
        lane_d  = lane_q;

        // shadow values follow the registers while idle, else at the boundary
        if (!act_i || my_wrap) begin
            lane_d.duty = duty_i;
            lane_d.sel  = sel_i;
        end

        if (!act_i) begin
            lane_d.out = 1'b0;
        end else if (byp_i) begin
            lane_d.out = 1'b1;
        end else if (my_stop) begin
            lane_d.out = 1'b0;
        end else begin
            lane_d.out = (my_tick < lane_q.duty);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign sel_o = lane_q.sel;
    assign pwm_o = lane_q.out;

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi #(
    parameter int NUM_CH = 4,
    parameter int DIV_W  = 16,
    parameter int DUTY_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_we,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic [NUM_CH-1:0]          pwm_o
);
    localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0]              out_en;
    logic [NUM_CH-1:0]              clk_en;
    logic [NUM_CH-1:0]              byp;
    logic [NUM_CH-1:0][DIV_W-1:0]   div;
    logic [NUM_CH-1:0][DUTY_W-1:0]  duty;
    logic [NUM_CH-1:0][SEL_W-1:0]   sel;

    logic [NUM_CH-1:0]              act;
    logic [NUM_CH-1:0][SEL_W-1:0]   sel_act;
    logic [NUM_CH-1:0]              gen_run;
    logic [NUM_CH-1:0][DUTY_W-1:0]  gen_tick;
    logic [NUM_CH-1:0]              gen_stop;
    logic [NUM_CH-1:0]              gen_wrap;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .DIV_W  (DIV_W),
        .DUTY_W (DUTY_W),
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .out_en    (out_en),
        .clk_en    (clk_en),
        .byp       (byp),
        .div       (div),
        .duty      (duty),
        .sel       (sel)
    );

    assign act = out_en & clk_en;

    // a generator runs while at least one running channel follows it
    always_comb begin
        gen_run = '0;
        for (int g = 0; g < NUM_CH; g++) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (act[c] && (sel_act[c] == SEL_W'(g))) begin
                    gen_run[g] = 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_gen
        pwm_timebase #(
            .DIV_W  (DIV_W),
            .DUTY_W (DUTY_W)
        ) tb_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (gen_run[g]),
            .div_i  (div[g]),
            .tick_o (gen_tick[g]),
            .stop_o (gen_stop[g]),
            .wrap_o (gen_wrap[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        pwm_lane #(
            .NUM_GEN (NUM_CH),
            .DUTY_W  (DUTY_W),
            .SEL_W   (SEL_W)
        ) lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_i      (act[c]),
            .byp_i      (byp[c]),
            .duty_i     (duty[c]),
            .sel_i      (sel[c]),
            .gen_tick_i (gen_tick),
            .gen_stop_i (gen_stop),
            .gen_wrap_i (gen_wrap),
            .sel_o      (sel_act[c]),
            .pwm_o      (pwm_o[c])
        );
    end

endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [31:0]               bus_rdata,
    input logic [NUM_CH-1:0]         pwm_o,
    input logic [NUM_CH-1:0]         act,
    input logic [NUM_CH-1:0]         byp,
    input logic [NUM_CH-1:0][SEL_W-1:0] sel_act,
    input logic [NUM_CH-1:0]         gen_stop,
    input logic [NUM_CH-1:0]         gen_wrap
);
    localparam int MAP_END = pwm_pkg::duty_ofs(NUM_CH, NUM_CH);

    logic unmapped;
    assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr >= ADDR_W'(MAP_END));

    // R2: upper bits of the clock-enable word read zero
    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(pwm_pkg::OFS_CLK_CTRL)) |-> (bus_rdata[31:NUM_CH] == '0));

    // R10: unmapped reads return zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R5: a stopped channel drives low after one register stage
        p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !act[c] |=> !pwm_o[c]);

        // R6: bypass on a running channel gives a high output
        p_bypass_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (act[c] && byp[c]) |=> pwm_o[c]);

        // R7: a channel on a stopped generator stays low without bypass
        p_stop_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (act[c] && !byp[c] && gen_stop[sel_act[c]]) |=> !pwm_o[c]);

        // R8: the followed generator changes only at a period boundary
        p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (act[c] && !gen_wrap[sel_act[c]]) |=> $stable(sel_act[c]));
    end

endmodule

bind pwm_multi pwm_multi_chk #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pwm_o     (pwm_o),
    .act       (act),
    .byp       (byp),
    .sel_act   (sel_act),
    .gen_stop  (gen_stop),
    .gen_wrap  (gen_wrap)
);

// File: tb/pwm_multi_tb.sv
module pwm_multi_tb_top;
    localparam int CLK_P  = 10;
    localparam int NCH    = 4;
    localparam int DUTYW  = 4;
    localparam int TICKS  = 1 << DUTYW;
    localparam int TR     = 4096;
    localparam int BIG    = 1 << 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_wr = 0;
    logic [NCH-1:0] trace [TR];

    pwm_multi #(
        .NUM_CH (NCH),
        .DIV_W  (16),
        .DUTY_W (DUTYW),
        .ADDR_W (8)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) trace[cyc % TR] = pwm_o;

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(posedge clk);
        #1;
        last_wr = cyc;
        bus_we  = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(posedge clk);
    endtask

    // compare samples j=0..n-1 taken at cycle w+1+j against the period model
    task automatic chk_wave(input string req, input int ch, input int w, input int n,
                            input int f1, input int d1, input int jsw, input int f2, input int d2);
        int bad = 0;
        int first = -1;
        logic fa = 1'b0;
        logic fe = 1'b0;
        while (cyc <= w + n + 2) @(negedge clk);
        for (int j = 0; j < n; j++) begin
            logic e;
            logic a;
            if (j < jsw) e = ((j % (TICKS * f1)) < (d1 * f1));
            else         e = (((j - jsw) % (TICKS * f2)) < (d2 * f2));
            a = trace[(w + 1 + j) % TR][ch];
            if (a !== e) begin
                if (first < 0) begin first = j; fa = a; fe = e; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s ch%0d sample %0d: got %0b expected %0b (%0d mismatches)",
                     req, ch, first, fa, fe, bad);
        end
    endtask

    function automatic logic [7:0] duty_a(input int c);
        return 8'(8'h18 + 4 * c);
    endfunction

    function automatic logic [7:0] div_a(input int c);
        return 8'(8'h08 + 4 * c);
    endfunction

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_rd("R1", 8'h00, 32'h0);
        chk_rd("R1", 8'h04, 32'h0);
        for (int c = 0; c < NCH; c++) begin
            chk_rd("R1", div_a(c), 32'h0);
            chk_rd("R1", duty_a(c), 32'h0);
        end
        checks++;
        if (pwm_o !== '0) begin
            errors++;
            $display("FAIL R1 outputs: got %b expected 0000", pwm_o);
        end

        // R2: field widths and unused bits
        for (int c = 0; c < NCH; c++) begin
            bus_wr(div_a(c), 32'hFFFF_FFFF);
            bus_wr(duty_a(c), 32'hFFFF_FFFF);
        end
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_wr(8'h00, 32'hFFFF_FFFF);
        chk_rd("R2", 8'h00, 32'h0000_0F0F);
        chk_rd("R2", 8'h04, 32'h0000_000F);
        for (int c = 0; c < NCH; c++) begin
            chk_rd("R2", div_a(c), 32'h0000_FFFF);
            chk_rd("R2", duty_a(c), 32'h0000_030F);
        end
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h04, 32'h0);
        for (int c = 0; c < NCH; c++) begin
            bus_wr(div_a(c), 32'h0);
            bus_wr(duty_a(c), 32'h0);
        end

        // R10: unmapped and unaligned writes are ignored, reads give zero
        bus_wr(8'h28, 32'hFFFF_FFFF);
        bus_wr(8'h40, 32'hFFFF_FFFF);
        bus_wr(8'h09, 32'hFFFF_FFFF);
        bus_wr(8'h01, 32'hFFFF_FFFF);
        bus_wr(8'h1A, 32'hFFFF_FFFF);
        chk_rd("R10", 8'h28, 32'h0);
        chk_rd("R10", 8'h09, 32'h0);
        chk_rd("R10", 8'h00, 32'h0);
        chk_rd("R10", 8'h04, 32'h0);
        chk_rd("R10", 8'h08, 32'h0);
        chk_rd("R10", 8'h18, 32'h0);

        // R3: every duty value with small divisors, from a clean enable
        bus_wr(8'h04, 32'h0000_000F);
        for (int f = 1; f <= 3; f++) begin
            for (int d = 0; d < TICKS; d++) begin
                bus_wr(8'h00, 32'h0);
                bus_wr(div_a(0), 32'(f));
                bus_wr(duty_a(0), 32'(d));
                bus_wr(8'h00, 32'h1);
                chk_wave("R3", 0, last_wr, 2 * TICKS * f, f, d, BIG, 1, 0);
            end
        end

        // R9: disable mid-period then re-enable restarts the period
        begin
            int w0;
            int w1;
            int w2;
            bus_wr(8'h00, 32'h0);
            bus_wr(div_a(0), 32'd3);
            bus_wr(duty_a(0), 32'd7);
            bus_wr(8'h00, 32'h1);
            w0 = last_wr;
            wait_cyc(w0 + 20);
            bus_wr(8'h00, 32'h0);
            w1 = last_wr;
            bus_wr(8'h00, 32'h1);
            w2 = last_wr;
            chk_wave("R9", 0, w1, 1, 1, 0, BIG, 1, 0);
            chk_wave("R9", 0, w2, 2 * TICKS * 3, 3, 7, BIG, 1, 0);
        end

        // R4: four channels on four generators, two select mappings
        for (int m = 0; m < 2; m++) begin
            int w;
            bus_wr(8'h00, 32'h0);
            for (int g = 0; g < NCH; g++) bus_wr(div_a(g), 32'(g + 1));
            for (int c = 0; c < NCH; c++) begin
                int s = (m == 0) ? ((c + 1) % NCH) : (NCH - 1 - c);
                int d = (m == 0) ? (c + 3) : (2 * c + 1);
                bus_wr(duty_a(c), 32'((s << 8) | d));
            end
            bus_wr(8'h00, 32'h0000_000F);
            w = last_wr;
            for (int c = 0; c < NCH; c++) begin
                int s = (m == 0) ? ((c + 1) % NCH) : (NCH - 1 - c);
                int d = (m == 0) ? (c + 3) : (2 * c + 1);
                chk_wave("R4", c, w, 2 * TICKS * (s + 1), s + 1, d, BIG, 1, 0);
            end
        end

        // R5: output enable alone, then both enables, then clock enable cleared
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h04, 32'h0);
        bus_wr(div_a(0), 32'd1);
        bus_wr(duty_a(0), 32'd8);
        bus_wr(8'h00, 32'h1);
        chk_wave("R5", 0, last_wr, 40, 1, 0, BIG, 1, 0);
        bus_wr(8'h04, 32'h1);
        chk_wave("R5", 0, last_wr, 2 * TICKS, 1, 8, BIG, 1, 0);
        bus_wr(8'h04, 32'h0);
        chk_wave("R5", 0, last_wr, 40, 1, 0, BIG, 1, 0);
        bus_wr(8'h04, 32'h0000_000F);

        // R6: bypass on a running channel
        bus_wr(8'h00, 32'h0000_0101);
        chk_wave("R6", 0, last_wr, 40, 1, TICKS, BIG, 1, 0);

        // R7: stopped generator, with and without bypass, then started
        bus_wr(8'h00, 32'h0);
        bus_wr(div_a(0), 32'd0);
        bus_wr(duty_a(0), 32'd5);
        bus_wr(8'h00, 32'h1);
        chk_wave("R7", 0, last_wr, 40, 1, 0, BIG, 1, 0);
        bus_wr(8'h00, 32'h0000_0101);
        chk_wave("R7", 0, last_wr, 40, 1, TICKS, BIG, 1, 0);
        bus_wr(8'h00, 32'h1);
        bus_wr(div_a(0), 32'd2);
        chk_wave("R7", 0, last_wr, 1, 1, 0, BIG, 1, 0);
        chk_wave("R7", 0, last_wr + 1, 2 * TICKS * 2, 2, 5, BIG, 1, 0);

        // R8: duty, divisor and select changes wait for the period boundary
        begin
            int w0;
            bus_wr(8'h00, 32'h0);
            bus_wr(div_a(0), 32'd2);
            bus_wr(duty_a(0), 32'd4);
            bus_wr(8'h00, 32'h1);
            w0 = last_wr;
            wait_cyc(w0 + 10);
            bus_wr(duty_a(0), 32'd12);
            chk_wave("R8", 0, w0, 96, 2, 4, 2 * TICKS, 2, 12);

            bus_wr(8'h00, 32'h0);
            bus_wr(div_a(0), 32'd2);
            bus_wr(duty_a(0), 32'd3);
            bus_wr(8'h00, 32'h1);
            w0 = last_wr;
            wait_cyc(w0 + 6);
            bus_wr(div_a(0), 32'd1);
            chk_wave("R8", 0, w0, 80, 2, 3, 2 * TICKS, 1, 3);

            bus_wr(8'h00, 32'h0);
            bus_wr(div_a(0), 32'd2);
            bus_wr(div_a(1), 32'd3);
            bus_wr(duty_a(0), 32'd5);
            bus_wr(8'h00, 32'h1);
            w0 = last_wr;
            wait_cyc(w0 + 12);
            bus_wr(duty_a(0), 32'h0000_0109);
            chk_wave("R8", 0, w0, 2 * TICKS + 2 * TICKS * 3, 2, 5, 2 * TICKS, 3, 9);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule